// File: doc/BRIEF.md
# Strided byte NVRAM with self-formatting partition header

This block is an 8 KB byte store placed behind a memory-mapped bus window. Every stored byte takes one 16-unit slot of the address space, so the byte index comes from the address bits just above the lowest four. The window is 0x20000 address units wide. Bus accesses of any size move one byte. A write takes the low 8 bits of the write data. A read returns one byte, zero-extended, in the cycle after the request.

When reset is released, an internal sequencer takes the array. It first zeroes every byte. It then writes a 16-byte free-partition header at the bottom of the array. The header holds a marker byte, a folded checksum, the array length in big-endian order and a 12-byte name filler. The `busy` output stays high for the whole of this sequence. While `busy` is high the bus side has no effect on the array.

Top module: `nvram_stride_fmt`

## Requirements
- R1: After reset is released, `busy` is high for exactly 2052 clock cycles. These are 2048 cycles that clear one 4-byte row each, then 4 cycles that write the header rows. `busy` then stays low until the next reset.
- R2: Once `busy` is low, every byte at index 16 or above reads 0x00, including bytes written before the last reset.
- R3: After initialisation, byte 0 reads 0x7F, byte 2 reads 0x20, byte 3 reads 0x00, and each of bytes 4 to 15 reads 0x77.
- R4: After initialisation, byte 1 reads 0x39. This value is formed as follows: sum the 16 header bytes with byte 1 counted as zero, add the low 8 bits of that sum to the sum shifted right by 8, and keep the low 8 bits.
- R5: The byte index is address bits [16:4]. Address bits [3:0] and bits [31:17] have no effect on which byte is accessed.
- R6: A write of any size (req_size 0 byte, 1 halfword, 2 word) stores only req_wdata[7:0] into the one addressed byte. Neighbouring bytes are unchanged.
- R7: `rsp_rdata` carries the addressed byte in bits [7:0], with zero in bits [31:8], in the cycle after an accepted read. In every other cycle, including the one after a write or an idle cycle, it is all zeros.
- R8: While `busy` is high, a bus write leaves the array unchanged and a bus read returns zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts the init sequence |
| req_valid | input | 1 | A bus request is present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size (0 byte, 1 half, 2 word); does not change behaviour |
| req_addr | input | 32 | Bus address; byte index in bits [16:4] |
| req_wdata | input | 32 | Write data; only bits [7:0] are stored |
| rsp_rdata | output | 32 | Read data, valid in the cycle after a read |
| busy | output | 1 | Init sequence in progress |

## Verification
The bench times the busy window and injects a write to an already cleared byte and a read of the freshly written marker byte during its last cycles. A design that accepts bus traffic while busy would leave a stray 0x5A in the array or return 0x7F early. It checks that the header checksum is 0x39 against an independently computed fold. A design that drops the carry byte would read 0x33, and one that leaves the fold untruncated would read a different value. The bench hits the same byte through different low nibbles, upper address bits and access sizes, so a design that decodes the wrong bits, or stores wide data, shows aliasing or corrupted neighbours. It also writes bytes before a second reset to catch an init that skips the clear phase.

// File: rtl/nvfmt_pkg.sv
package nvfmt_pkg;

   localparam int unsigned HDR_BYTES  = 16;
   localparam logic [7:0]  FREE_MAGIC = 8'h7F;
   localparam logic [7:0]  NAME_FILL  = 8'h77;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [1:0] {
      SEQ_CLEAR = 2'd0,
      SEQ_HDR   = 2'd1,
      SEQ_DONE  = 2'd2
   } seq_state_e;

   // header byte with the checksum slot held at zero
   function automatic logic [7:0] hdr_raw(input int unsigned pos, input int unsigned len);
      logic [15:0] l16;
      l16 = len[15:0];
      case (pos)
         0:       return FREE_MAGIC;
         1:       return 8'h00;
         2:       return l16[15:8];
         3:       return l16[7:0];
         default: return NAME_FILL;
      endcase
   endfunction

   // wide sum folded back onto itself, truncated to a byte
   function automatic logic [7:0] hdr_fold_sum(input int unsigned len);
      logic [15:0] acc;
      logic [15:0] fold;
      acc = '0;
      for (int unsigned i = 0; i < HDR_BYTES; i++) begin
         acc = acc + 16'(hdr_raw(i, len));
      end
      fold = 16'(acc[7:0]) + 16'(acc[15:8]);
      return fold[7:0];
   endfunction

endpackage

// File: rtl/nvfmt_addr_dec.sv
module nvfmt_addr_dec #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned STRIDE_LOG2 = 4,
   parameter int unsigned IDX_W       = 13,
   parameter int unsigned LANES       = 4,
   parameter int unsigned LANE_W      = 2,
   parameter int unsigned ROW_W       = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ROW_W-1:0]  row,
   output logic [LANE_W-1:0] lane
);

   logic [IDX_W-1:0] idx;
   logic             unused_addr_bits;

   assign idx              = addr[STRIDE_LOG2 +: IDX_W];
   assign unused_addr_bits = ^{addr[STRIDE_LOG2-1:0], addr[ADDR_W-1:STRIDE_LOG2+IDX_W]};

   generate
      if (LANES == 1) begin : g_single_lane
         assign row  = idx;
         assign lane = '0;
      end else begin : g_multi_lane
         assign row  = idx[IDX_W-1:LANE_W];
         assign lane = idx[LANE_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/nvfmt_lane_ram.sv
module nvfmt_lane_ram #(
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned AW    = 11
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            mem[addr] <= wdata;
         end else begin
            rdata <= mem[addr];
         end
      end
   end

endmodule

// File: rtl/nvfmt_init_seq.sv
module nvfmt_init_seq
   import nvfmt_pkg::*;
#(
   parameter int unsigned NV_BYTES = 8192,
   parameter int unsigned LANES    = 4,
   parameter int unsigned ROWS     = 2048,
   parameter int unsigned ROW_W    = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               busy,
   output logic               wr_en,
   output logic [ROW_W-1:0]   wr_row,
   output logic [LANES*8-1:0] wr_data
);

   localparam int unsigned HDR_ROWS = HDR_BYTES / LANES;
   localparam logic [7:0]  CKSUM    = hdr_fold_sum(NV_BYTES);

   seq_state_e       state;
   logic [ROW_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_CLEAR;
         ptr   <= '0;
      end else begin
         case (state)
            SEQ_CLEAR: begin
               if (ptr == ROW_W'(ROWS - 1)) begin
                  state <= SEQ_HDR;
                  ptr   <= '0;
               end else begin
                  ptr <= ptr + 1'b1;
               end
            end
            SEQ_HDR: begin
               if (ptr == ROW_W'(HDR_ROWS - 1)) begin
                  state <= SEQ_DONE;
                  ptr   <= '0;
               end else begin
                  ptr <= ptr + 1'b1;
               end
            end
            default: begin
               state <= SEQ_DONE;
            end
         endcase
      end
   end

   assign busy   = (state != SEQ_DONE);
   assign wr_en  = busy;
   assign wr_row = ptr;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_data
         logic [7:0] hdr_b;
         always_comb begin
            hdr_b = hdr_raw(int'(ptr) * LANES + l, NV_BYTES);
            if ((int'(ptr) * LANES + l) == 1) begin
               hdr_b = CKSUM;
            end
         end
         assign wr_data[l*8 +: 8] = (state == SEQ_HDR) ? hdr_b : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/nvram_stride_fmt.sv
module nvram_stride_fmt
   import nvfmt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NV_BYTES    = 8192,
   parameter int unsigned STRIDE_LOG2 = 4,
   parameter int unsigned LANES       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              busy
);

   localparam int unsigned IDX_W       = $clog2(NV_BYTES);
   localparam int unsigned LANE_W      = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int unsigned ROWS        = NV_BYTES / LANES;
   localparam int unsigned ROW_W       = $clog2(ROWS);
   localparam int unsigned INIT_CYCLES = ROWS + HDR_BYTES / LANES;

   generate
      if (NV_BYTES < 2 * HDR_BYTES || (NV_BYTES & (NV_BYTES - 1)) != 0 || NV_BYTES > 32768) begin : g_bad_bytes
         $error("NV_BYTES must be a power of two between 32 and 32768");
      end
      if (LANES == 0 || (LANES & (LANES - 1)) != 0 || (HDR_BYTES % LANES) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two dividing the header size");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must be at least 16");
      end
      if (ADDR_W < STRIDE_LOG2 + IDX_W + 1 || STRIDE_LOG2 == 0) begin : g_bad_addr
         $error("ADDR_W too narrow for the strided window");
      end
   endgenerate

   logic [ROW_W-1:0]   bus_row;
   logic [LANE_W-1:0]  bus_lane;
   logic               init_we;
   logic [ROW_W-1:0]   init_row;
   logic [LANES*8-1:0] init_data;
   logic               bus_wr;
   logic               bus_rd;
   logic [ROW_W-1:0]   ram_addr;
   logic [7:0]         ram_q [LANES];
   logic               rd_ok;
   logic [LANE_W-1:0]  rd_lane;
   acc_size_e          unused_size;
   logic               unused_wdata;

   assign unused_size  = acc_size_e'(req_size);
   assign unused_wdata = ^req_wdata[DATA_W-1:8];

   nvfmt_addr_dec #(
      .ADDR_W      (ADDR_W),
      .STRIDE_LOG2 (STRIDE_LOG2),
      .IDX_W       (IDX_W),
      .LANES       (LANES),
      .LANE_W      (LANE_W),
      .ROW_W       (ROW_W)
   ) i_dec (
      .addr (req_addr),
      .row  (bus_row),
      .lane (bus_lane)
   );

   nvfmt_init_seq #(
      .NV_BYTES (NV_BYTES),
      .LANES    (LANES),
      .ROWS     (ROWS),
      .ROW_W    (ROW_W)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .wr_en   (init_we),
      .wr_row  (init_row),
      .wr_data (init_data)
   );

   assign bus_wr   = req_valid &  req_we & ~busy;
   assign bus_rd   = req_valid & ~req_we & ~busy;
   assign ram_addr = init_we ? init_row : bus_row;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic       hit;
         logic       en;
         logic       we;
         logic [7:0] wd;
         assign hit = (bus_lane == LANE_W'(l));
         assign we  = init_we | (bus_wr & hit);
         assign en  = init_we | (hit & (bus_wr | bus_rd));
         assign wd  = init_we ? init_data[l*8 +: 8] : req_wdata[7:0];

         nvfmt_lane_ram #(
            .DEPTH (ROWS),
            .AW    (ROW_W)
         ) i_ram (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .addr  (ram_addr),
            .wdata (wd),
            .rdata (ram_q[l])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ok   <= 1'b0;
         rd_lane <= '0;
      end else begin
         rd_ok   <= bus_rd;
         rd_lane <= bus_lane;
      end
   end

   always_comb begin
      rsp_rdata = '0;
      if (rd_ok) begin
         rsp_rdata[7:0] = ram_q[rd_lane];
      end
   end

endmodule

// File: rtl/nvfmt_chk.sv
module nvfmt_chk #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BUSY_CYCLES = 2052
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_we,
   input logic              busy,
   input logic [DATA_W-1:0] rsp_rdata
);

   logic [31:0] busy_cnt;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         seen     <= 1'b0;
      end else begin
         seen <= 1'b1;
         if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
         end
      end
   end

   p_busy_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> busy);

   p_busy_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cnt == BUSY_CYCLES));

   p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rdata[DATA_W-1:8] == '0);

   p_no_read_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_we) |=> (rsp_rdata == '0));

   p_busy_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && busy) |=> (rsp_rdata == '0));

endmodule

bind nvram_stride_fmt nvfmt_chk #(
   .DATA_W      (DATA_W),
   .BUSY_CYCLES (INIT_CYCLES)
) i_nvfmt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_we    (req_we),
   .busy      (busy),
   .rsp_rdata (rsp_rdata)
);

// File: tb/test_nvram_stride_fmt.sv
module test_nvram_stride_fmt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        busy;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [7:0] model [512];

   always #4 clk = ~clk;

   nvram_stride_fmt i_nvram_stride_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_size  (req_size),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_rdata (rsp_rdata),
      .busy      (busy)
   );

   function automatic logic [7:0] ref_cksum();
      int s;
      s = 'h7F + 'h00 + 'h20 + 'h00 + 12 * 'h77;
      return 8'((s & 255) + (s >> 8));
   endfunction

   function automatic logic [7:0] ref_hdr(input int i);
      if (i == 0) return 8'h7F;
      if (i == 1) return ref_cksum();
      if (i == 2) return 8'h20;
      if (i == 3) return 8'h00;
      return 8'h77;
   endfunction

   function automatic int slot_of(input int idx);
      if (idx < 256) return idx;
      if (idx >= 7936) return idx - 7680;
      return -1;
   endfunction

   function automatic int idx_of_slot(input int k);
      return (k < 256) ? k : k + 7680;
   endfunction

   function automatic logic [31:0] addr_of(input int idx, input logic [3:0] nib, input logic [14:0] hi);
      logic [12:0] i13;
      i13 = idx[12:0];
      return {hi, i13, nib};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 512; k++) model[k] = 8'h00;
      for (int k = 0; k < 16; k++) model[k] = ref_hdr(k);
   endtask

   task automatic do_reset();
      req_valid = 1'b0;
      req_we    = 1'b0;
      rst_n     = 1'b0;
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         chk("R1 busy during reset", {31'd0, busy}, 32'd1);
         chk("R7 rdata zero during reset", rsp_rdata, 32'd0);
      end
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic wait_init(output int cyc);
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] data, input logic [1:0] sz,
                     input logic [3:0] nib, input logic [14:0] hi);
      int k;
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_size  = sz;
      req_addr  = addr_of(idx, nib, hi);
      req_wdata = data;
      @(negedge clk);
      chk("R7 rdata zero after write", rsp_rdata, 32'd0);
      req_valid = 1'b0;
      req_we    = 1'b0;
      k = slot_of(idx);
      if (k >= 0) model[k] = data[7:0];
   endtask

   task automatic rd(input int idx, input logic [1:0] sz, input logic [3:0] nib,
                     input logic [14:0] hi, output logic [31:0] d);
      req_valid = 1'b1;
      req_we    = 1'b0;
      req_size  = sz;
      req_addr  = addr_of(idx, nib, hi);
      req_wdata = $urandom;
      @(negedge clk);
      d = rsp_rdata;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int          cyc;
      int          errs;
      logic [31:0] d;
      logic [31:0] r;
      void'($urandom(32'h5EED_0042));

      // first init: poke the bus in the last busy cycles (R1, R8)
      do_reset();
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         req_valid = 1'b0;
         req_we    = 1'b0;
         if (cyc == 2050) begin
            req_valid = 1'b1;
            req_we    = 1'b1;
            req_addr  = addr_of(5000, 4'h0, 15'h0);
            req_wdata = 32'h0000_005A;
         end
         if (cyc == 2051) begin
            req_valid = 1'b1;
            req_addr  = addr_of(0, 4'h0, 15'h0);
         end
         @(negedge clk);
         if (cyc == 2051) chk("R8 read while busy returns zero", rsp_rdata, 32'd0);
      end
      req_valid = 1'b0;
      req_we    = 1'b0;
      chk("R1 busy cycle count", cyc, 32'd2052);

      errs = 0;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (busy) errs++;
      end
      chk("R1 busy stays low", errs, 32'd0);

      // header contents (R3, R4)
      for (int i = 0; i < 16; i++) begin
         rd(i, 2'(i % 3), 4'(i), 15'(i * 37), d);
         if (i == 1) chk("R4 checksum byte", d, 32'h39);
         else        chk("R3 header byte", d, {24'd0, ref_hdr(i)});
      end
      chk("R4 bench checksum model", {24'd0, ref_cksum()}, 32'h39);

      // cleared body and busy write ignored (R2, R8)
      rd(5000, 2'd0, 4'h0, 15'h0, d);
      chk("R8 write while busy ignored", d, 32'd0);
      rd(16, 2'd2, 4'h9, 15'h0, d);   chk("R2 byte 16 cleared", d, 32'd0);
      rd(1000, 2'd1, 4'h1, 15'h0, d); chk("R2 byte 1000 cleared", d, 32'd0);
      rd(8191, 2'd0, 4'hF, 15'h7FFF, d); chk("R2 last byte cleared", d, 32'd0);

      // idle cycle after a read yields zero (R7)
      rd(0, 2'd0, 4'h0, 15'h0, d);
      chk("R7 read data zero-extended", d, 32'h7F);
      @(negedge clk);
      chk("R7 rdata zero after idle", rsp_rdata, 32'd0);

      // address decode aliasing (R5)
      wr(300, 32'hFFFF_FFC4, 2'd2, 4'hF, 15'h0008);
      rd(300, 2'd0, 4'h3, 15'h0, d);
      chk("R5 low nibble and high bits ignored", d, 32'hC4);
      rd(300, 2'd1, 4'h0, 15'h4001, d);
      chk("R5 alias through bits above 16", d, 32'hC4);
      wr(301, 32'h0000_0011, 2'd0, 4'h0, 15'h0);
      rd(300, 2'd0, 4'h0, 15'h0, d);
      chk("R6 neighbour byte unchanged", d, 32'hC4);
      rd(301, 2'd0, 4'h8, 15'h0, d);
      chk("R5 adjacent slot distinct", d, 32'h11);

      // sizes store only the low byte (R6)
      wr(7999, 32'h1234_56A5, 2'd1, 4'h2, 15'h0);
      rd(7999, 2'd2, 4'h0, 15'h0, d);
      chk("R6 halfword write stores low byte", d, 32'hA5);
      wr(8000, 32'hDEAD_BE3C, 2'd2, 4'h0, 15'h0);
      rd(8000, 2'd0, 4'h0, 15'h0, d);
      chk("R6 word write stores low byte", d, 32'h3C);

      // constrained random traffic against the model (R5, R6, R7)
      for (int n = 0; n < 400; n++) begin
         int k;
         r = $urandom;
         k = int'(r % 512);
         if (r[9]) begin
            wr(idx_of_slot(k), $urandom, 2'(r[11:10] % 3), 4'($urandom), 15'($urandom));
         end else begin
            rd(idx_of_slot(k), 2'(r[11:10] % 3), 4'($urandom), 15'($urandom), d);
            chk("R5/R6 random read vs model", d, {24'd0, model[k]});
         end
      end

      // reset clears earlier contents and rebuilds the header (R1, R2, R4)
      wr(100, 32'hC3, 2'd0, 4'h0, 15'h0);
      wr(8100, 32'hC3, 2'd0, 4'h0, 15'h0);
      wr(1, 32'h00, 2'd0, 4'h0, 15'h0);
      do_reset();
      wait_init(cyc);
      chk("R1 busy cycle count after second reset", cyc, 32'd2052);
      rd(100, 2'd0, 4'h0, 15'h0, d);  chk("R2 written byte cleared by reset", d, 32'd0);
      rd(8100, 2'd0, 4'h0, 15'h0, d); chk("R2 high byte cleared by reset", d, 32'd0);
      rd(1, 2'd0, 4'h0, 15'h0, d);    chk("R4 checksum rebuilt", d, 32'h39);
      rd(2, 2'd0, 4'h0, 15'h0, d);    chk("R3 length high byte", d, 32'h20);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule